// File: doc/BRIEF.md
# Shared Memory Bus Interface with Buffered and Pass-Through Modes

This block lets a host processor and an on-chip protocol engine share one memory. The memory is either a small internal RAM of 8K x 16 words or an external RAM of up to 64K words. A static mode input picks between the two arrangements. In the isolated (buffered) mode the host buses never touch the memory bus directly. Host addresses are folded into the internal 8K window, and the host data path is switched off whenever the engine owns the memory. In the pass-through (transparent) mode a host cycle places the host address on the memory bus. An engine cycle drives the memory address outward onto the external address bus, and the chip-select, output-enable and write strobes address external RAM.

An address latch in front of the host path supports hosts that multiplex address and data on one bus. While the latch-enable input is high, the latch passes the host address straight through. While it is low, the latch holds the last address it saw. A fixed-priority arbiter starts one memory cycle at a time and always prefers the engine. Each cycle lasts exactly two clocks: a select phase, then a strobe phase. The host sees a ready pulse in the strobe phase of its own cycle and waits for it.

Top module: `shmem_bus_if`

## Requirements
- R1: While reset is high, and in the first cycle after it, `mem_cs_n`, `mem_oe_n` and `mem_we_n` are 1, and `host_ready`, `eng_ack`, `host_rd_drive`, `host_wr_accept`, `ext_addr_oe` and `host_range_err` are 0.
- R2: With `host_ale` = 1 the host address passes through the latch unchanged. With `host_ale` = 0 the host path uses the address present at the last clock edge where `host_ale` was 1.
- R3: The engine has priority. When both requests are present in an idle cycle, the engine cycle runs first and `host_ready` stays 0 until the engine cycle finishes. The host cycle starts in the first idle cycle after that.
- R4: A granted cycle takes two clocks after the request edge. In the select phase only `mem_cs_n` is 0. In the strobe phase `mem_cs_n` stays 0 and either `mem_oe_n` is 0 (read) or `mem_we_n` is 0 (write). All three return to 1 together in the next cycle. `host_ready` or `eng_ack` is 1 only in the strobe phase.
- R5: In isolated mode (`mode_xparent` = 0), a host write raises `host_wr_accept` and puts the host data on `mem_wdata`. A host read raises `host_rd_drive` in the strobe phase and presents `mem_rdata` on `host_rdata`. During an engine cycle both host data enables are 0.
- R6: In isolated mode, `mem_addr` carries the engine address (low 13 bits) during engine cycles and the latched host address during host cycles. The live host address input has no effect on an engine cycle.
- R7: In pass-through mode (`mode_xparent` = 1), a host cycle puts the full 16-bit host address on `mem_addr` with `ext_addr_oe` = 0. An engine cycle raises `ext_addr_oe` and drives the engine address on `ext_addr_out`. `ext_addr_oe` is never 1 in isolated mode.
- R8: In isolated mode, a requested host address at or above 0x2000 raises `host_range_err`, and no cycle starts for it. In pass-through mode such addresses are served normally.
- R9: `int_ram_sel` is 1 only during an active cycle in which `mem_en_in_n` is 0. In isolated mode `mem_en_in_n` is wired back from `mem_cs_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_xparent | input | 1 | 1 = pass-through to external RAM, 0 = isolated internal RAM |
| host_ale | input | 1 | Address latch enable; high = transparent |
| host_addr_in | input | 16 | Host address bus |
| host_req | input | 1 | Host access request, held until ready |
| host_we | input | 1 | Host access is a write |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Read data toward the host |
| host_rd_drive | output | 1 | Data buffer directed toward the host |
| host_wr_accept | output | 1 | Data buffer directed toward memory |
| host_ready | output | 1 | Host cycle completes this clock |
| host_range_err | output | 1 | Host address outside the internal window |
| eng_req | input | 1 | Engine access request |
| eng_we | input | 1 | Engine access is a write |
| eng_addr | input | 16 | Engine memory address |
| eng_wdata | input | 16 | Engine write data |
| eng_ack | output | 1 | Engine cycle completes this clock |
| mem_addr | output | 16 | Memory-side address |
| mem_wdata | output | 16 | Memory-side write data |
| mem_rdata | input | 16 | Memory-side read data |
| ext_addr_out | output | 16 | Address driven outward in pass-through engine cycles |
| ext_addr_oe | output | 1 | Enable for `ext_addr_out` |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_en_in_n | input | 1 | Internal RAM select input, active low |
| int_ram_sel | output | 1 | Internal RAM selected this cycle |

## Verification
A request driven between edges is granted at the next rising edge. The select-phase results (chip select, memory address, outward address enable) therefore appear one clock after the request. The strobe-phase results (output enable or write, ready or acknowledge, data enables and read data) appear two clocks after it. Everything is idle again at three clocks. A held-off host request starts three clocks after the engine's request. The bench drives all inputs on the falling edge and samples each result on the falling edge of exactly the clock where it is due. A monitor compares the host read data against a queue of expected words whenever a read completes, so a read that finishes early, late or twice is caught as a miscompare.

// File: rtl/sbi_pkg.sv
package sbi_pkg;

    localparam int SBI_AW = 16;
    localparam int SBI_DW = 16;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_SEL  = 2'd1,
        PH_STRB = 2'd2
    } phase_e;

    typedef enum logic {
        OWN_HOST = 1'b0,
        OWN_ENG  = 1'b1
    } owner_e;

    typedef struct packed {
        owner_e              owner;
        logic                we;
        logic [SBI_AW-1:0]   addr;
        logic [SBI_DW-1:0]   wdata;
    } mem_cyc_t;

    // True when the address lies inside the internal window of 2**iaw words.
    function automatic logic fits_window(input logic [SBI_AW-1:0] a, input int iaw);
        logic [SBI_AW-1:0] hi_mask;
        hi_mask = ~({SBI_AW{1'b1}} >> (SBI_AW - iaw));
        return (a & hi_mask) == '0;
    endfunction

    // Address as presented to memory: folded into the window in isolated mode.
    function automatic logic [SBI_AW-1:0] fold_addr(input logic [SBI_AW-1:0] a,
                                                     input int iaw,
                                                     input logic xparent);
        logic [SBI_AW-1:0] lo_mask;
        lo_mask = {SBI_AW{1'b1}} >> (SBI_AW - iaw);
        return xparent ? a : (a & lo_mask);
    endfunction

endpackage

// File: rtl/sbi_addr_latch.sv
module sbi_addr_latch #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ale,
    input  logic [AW-1:0] addr_in,
    output logic [AW-1:0] addr_eff
);
    logic [AW-1:0] held_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q <= '0;
        end else if (ale) begin
            held_q <= addr_in;
        end
    end

    assign addr_eff = ale ? addr_in : held_q;
endmodule

// File: rtl/sbi_arbiter.sv
module sbi_arbiter (
    input  logic idle,
    input  logic eng_req,
    input  logic host_req,
    input  logic host_blocked,
    output logic grant_eng,
    output logic grant_host
);
    always_comb begin
        grant_eng  = idle && eng_req;
        grant_host = idle && host_req && !host_blocked && !eng_req;
    end
endmodule

// File: rtl/sbi_cycle_seq.sv
module sbi_cycle_seq
    import sbi_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     start,
    input  mem_cyc_t next_cyc,
    output phase_e   phase,
    output mem_cyc_t cur,
    output logic     cs_n,
    output logic     oe_n,
    output logic     we_n
);
    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            cur   <= '0;
        end else begin
            unique case (phase)
                PH_IDLE: begin
                    if (start) begin
                        phase <= PH_SEL;
                        cur   <= next_cyc;
                    end
                end
                PH_SEL:  phase <= PH_STRB;
                PH_STRB: phase <= PH_IDLE;
                default: phase <= PH_IDLE;
            endcase
        end
    end

    always_comb begin
        cs_n = (phase == PH_IDLE);
        oe_n = !((phase == PH_STRB) && !cur.we);
        we_n = !((phase == PH_STRB) &&  cur.we);
    end
endmodule

// File: rtl/sbi_bus_steer.sv
module sbi_bus_steer
    import sbi_pkg::*;
#(
    parameter int INT_AW = 13
) (
    input  logic              xparent,
    input  phase_e            phase,
    input  mem_cyc_t          cur,
    input  logic [SBI_DW-1:0] mem_rdata,
    input  logic              mem_en_in_n,
    output logic [SBI_AW-1:0] mem_addr,
    output logic [SBI_DW-1:0] mem_wdata,
    output logic [SBI_AW-1:0] ext_addr_out,
    output logic              ext_addr_oe,
    output logic [SBI_DW-1:0] host_rdata,
    output logic              host_rd_drive,
    output logic              host_wr_accept,
    output logic              host_ready,
    output logic              eng_ack,
    output logic              int_ram_sel
);
    logic active, strb, host_cyc, eng_cyc;

    always_comb begin
        active   = (phase != PH_IDLE);
        strb     = (phase == PH_STRB);
        host_cyc = active && (cur.owner == OWN_HOST);
        eng_cyc  = active && (cur.owner == OWN_ENG);

        mem_addr  = active ? fold_addr(cur.addr, INT_AW, xparent) : '0;
        mem_wdata = (active && cur.we) ? cur.wdata : '0;

        // Engine address travels outward only in pass-through mode.
        ext_addr_oe  = xparent && eng_cyc;
        ext_addr_out = ext_addr_oe ? cur.addr : '0;

        // Host data buffers: inward on writes, outward on reads, off for engine.
        host_wr_accept = host_cyc && cur.we;
        host_rd_drive  = host_cyc && !cur.we && strb;
        host_rdata     = host_rd_drive ? mem_rdata : '0;

        host_ready  = host_cyc && strb;
        eng_ack     = eng_cyc && strb;
        int_ram_sel = active && !mem_en_in_n;
    end
endmodule

// File: rtl/shmem_bus_if.sv
module shmem_bus_if
    import sbi_pkg::*;
#(
    parameter int INT_AW = 13
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_xparent,
    input  logic              host_ale,
    input  logic [SBI_AW-1:0] host_addr_in,
    input  logic              host_req,
    input  logic              host_we,
    input  logic [SBI_DW-1:0] host_wdata,
    output logic [SBI_DW-1:0] host_rdata,
    output logic              host_rd_drive,
    output logic              host_wr_accept,
    output logic              host_ready,
    output logic              host_range_err,
    input  logic              eng_req,
    input  logic              eng_we,
    input  logic [SBI_AW-1:0] eng_addr,
    input  logic [SBI_DW-1:0] eng_wdata,
    output logic              eng_ack,
    output logic [SBI_AW-1:0] mem_addr,
    output logic [SBI_DW-1:0] mem_wdata,
    input  logic [SBI_DW-1:0] mem_rdata,
    output logic [SBI_AW-1:0] ext_addr_out,
    output logic              ext_addr_oe,
    output logic              mem_cs_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    input  logic              mem_en_in_n,
    output logic              int_ram_sel
);
    logic [SBI_AW-1:0] host_addr_eff;
    logic              grant_eng, grant_host, idle;
    phase_e            phase;
    mem_cyc_t          cur, next_cyc;

    sbi_addr_latch #(.AW(SBI_AW)) latch_i (
        .clk      (clk),
        .rst      (rst),
        .ale      (host_ale),
        .addr_in  (host_addr_in),
        .addr_eff (host_addr_eff)
    );

    always_comb begin
        host_range_err = !mode_xparent && host_req && !fits_window(host_addr_eff, INT_AW);
        idle           = (phase == PH_IDLE);
    end

    sbi_arbiter arb_i (
        .idle         (idle),
        .eng_req      (eng_req),
        .host_req     (host_req),
        .host_blocked (host_range_err),
        .grant_eng    (grant_eng),
        .grant_host   (grant_host)
    );

    always_comb begin
        if (grant_eng) begin
            next_cyc.owner = OWN_ENG;
            next_cyc.we    = eng_we;
            next_cyc.addr  = eng_addr;
            next_cyc.wdata = eng_wdata;
        end else begin
            next_cyc.owner = OWN_HOST;
            next_cyc.we    = host_we;
            next_cyc.addr  = host_addr_eff;
            next_cyc.wdata = host_wdata;
        end
    end

    sbi_cycle_seq seq_i (
        .clk      (clk),
        .rst      (rst),
        .start    (grant_eng || grant_host),
        .next_cyc (next_cyc),
        .phase    (phase),
        .cur      (cur),
        .cs_n     (mem_cs_n),
        .oe_n     (mem_oe_n),
        .we_n     (mem_we_n)
    );

    sbi_bus_steer #(.INT_AW(INT_AW)) steer_i (
        .xparent        (mode_xparent),
        .phase          (phase),
        .cur            (cur),
        .mem_rdata      (mem_rdata),
        .mem_en_in_n    (mem_en_in_n),
        .mem_addr       (mem_addr),
        .mem_wdata      (mem_wdata),
        .ext_addr_out   (ext_addr_out),
        .ext_addr_oe    (ext_addr_oe),
        .host_rdata     (host_rdata),
        .host_rd_drive  (host_rd_drive),
        .host_wr_accept (host_wr_accept),
        .host_ready     (host_ready),
        .eng_ack        (eng_ack),
        .int_ram_sel    (int_ram_sel)
    );
endmodule

// File: rtl/sbi_checker.sv
module sbi_checker (
    input logic clk,
    input logic rst,
    input logic mode_xparent,
    input logic host_req,
    input logic host_range_err,
    input logic eng_req,
    input logic host_ready,
    input logic host_rd_drive,
    input logic host_wr_accept,
    input logic eng_ack,
    input logic ext_addr_oe,
    input logic mem_cs_n,
    input logic mem_oe_n,
    input logic mem_we_n
);
    AST_STROBES_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(!mem_oe_n && !mem_we_n)); // R4
    AST_STROBE_NEEDS_CS: assert property (@(posedge clk) disable iff (rst)
        (!mem_oe_n || !mem_we_n) |-> !mem_cs_n); // R4
    AST_CS_LEADS_STROBE: assert property (@(posedge clk) disable iff (rst)
        ($fell(mem_oe_n) || $fell(mem_we_n)) |-> $past(!mem_cs_n)); // R4
    AST_READY_IN_STROBE: assert property (@(posedge clk) disable iff (rst)
        (host_ready || eng_ack) |-> (!mem_oe_n || !mem_we_n)); // R4
    AST_BUF_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(host_rd_drive && host_wr_accept)); // R5
    AST_ENG_ISOLATES_HOST: assert property (@(posedge clk) disable iff (rst)
        eng_ack |-> (!host_rd_drive && !host_wr_accept && !host_ready)); // R5
    AST_ENG_FIRST: assert property (@(posedge clk) disable iff (rst)
        (mem_cs_n && eng_req && host_req) |=> ##1 eng_ack); // R3
    AST_RANGE_NO_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (mem_cs_n && host_range_err && !eng_req) |=> mem_cs_n); // R8
    AST_EXT_DRIVE_MODE: assert property (@(posedge clk) disable iff (rst)
        ext_addr_oe |-> (mode_xparent && !mem_cs_n)); // R7
endmodule

bind shmem_bus_if sbi_checker chk_i (
    .clk            (clk),
    .rst            (rst),
    .mode_xparent   (mode_xparent),
    .host_req       (host_req),
    .host_range_err (host_range_err),
    .eng_req        (eng_req),
    .host_ready     (host_ready),
    .host_rd_drive  (host_rd_drive),
    .host_wr_accept (host_wr_accept),
    .eng_ack        (eng_ack),
    .ext_addr_oe    (ext_addr_oe),
    .mem_cs_n       (mem_cs_n),
    .mem_oe_n       (mem_oe_n),
    .mem_we_n       (mem_we_n)
);

// File: tb/shmem_bus_if_tb_top.sv
module shmem_bus_if_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mode_xparent = 1'b0;
    logic        host_ale = 1'b1;
    logic [15:0] host_addr_in = '0;
    logic        host_req = 1'b0;
    logic        host_we = 1'b0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic        host_rd_drive, host_wr_accept, host_ready, host_range_err;
    logic        eng_req = 1'b0;
    logic        eng_we = 1'b0;
    logic [15:0] eng_addr = '0;
    logic [15:0] eng_wdata = '0;
    logic        eng_ack;
    logic [15:0] mem_addr, mem_wdata, mem_rdata, ext_addr_out;
    logic        ext_addr_oe, mem_cs_n, mem_oe_n, mem_we_n, mem_en_in_n, int_ram_sel;

    logic [15:0] tbmem [0:255];
    logic [15:0] exp_q [$];
    int          n_vec = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk; // 50 MHz

    // Memory model shared by both modes; loopback of chip select in isolated mode.
    assign mem_rdata   = tbmem[mem_addr[7:0]];
    assign mem_en_in_n = mode_xparent ? 1'b1 : mem_cs_n;
    always @(posedge clk) if (!mem_we_n) tbmem[mem_addr[7:0]] <= mem_wdata;

    shmem_bus_if dut_i (.*);

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    // Monitor: compare every completed host read with the scoreboard queue.
    always @(negedge clk) begin
        if (!rst && host_ready && host_rd_drive) begin
            n_vec++;
            if (exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL R5 unexpected read: got %h expected none", host_rdata);
            end else begin
                logic [15:0] e;
                e = exp_q.pop_front();
                if (host_rdata !== e) begin
                    n_bad++;
                    $display("FAIL R5 read data: got %h expected %h", host_rdata, e);
                end
            end
        end
    end

    task automatic host_op(input logic [15:0] drv, input logic [15:0] exp_a,
                           input logic we, input logic [15:0] d);
        @(negedge clk);
        host_addr_in = drv; host_we = we; host_wdata = d; host_req = 1'b1;
        if (!we) exp_q.push_back(d);
        @(negedge clk);
        chk("R4 select cs", mem_cs_n, 1'b0);
        chk("R4 select oe", mem_oe_n, 1'b1);
        chk("R4 select we", mem_we_n, 1'b1);
        chk(mode_xparent ? "R7 host addr" : "R6 host addr", mem_addr, exp_a);
        chk("R7 no outward addr on host", ext_addr_oe, 1'b0);
        chk("R9 ram select", int_ram_sel, !mode_xparent);
        @(negedge clk);
        chk("R4 strobe oe", mem_oe_n, we);
        chk("R4 strobe we", mem_we_n, !we);
        chk("R4 host ready", host_ready, 1'b1);
        if (we) begin
            chk("R5 write buffer in", host_wr_accept, 1'b1);
            chk("R5 write data", mem_wdata, d);
        end else begin
            chk("R5 read buffer out", host_rd_drive, 1'b1);
        end
        host_req = 1'b0;
        @(negedge clk);
        chk("R4 idle cs", mem_cs_n, 1'b1);
        chk("R4 idle strobes", {mem_oe_n, mem_we_n}, 2'b11);
    endtask

    task automatic eng_op(input logic [15:0] a, input logic we, input logic [15:0] d);
        @(negedge clk);
        eng_addr = a; eng_we = we; eng_wdata = d; eng_req = 1'b1;
        host_addr_in = 16'h00F0; // must not leak into an engine cycle
        @(negedge clk);
        chk("R6 engine addr", mem_addr, mode_xparent ? a : (a & 16'h1FFF));
        chk("R7 outward enable", ext_addr_oe, mode_xparent);
        if (mode_xparent) chk("R7 outward addr", ext_addr_out, a);
        chk("R5 host buffers off", {host_rd_drive, host_wr_accept}, 2'b00);
        @(negedge clk);
        chk("R4 engine ack", eng_ack, 1'b1);
        chk("R3 host not ready in engine cycle", host_ready, 1'b0);
        chk("R5 host buffers off strobe", {host_rd_drive, host_wr_accept}, 2'b00);
        eng_req = 1'b0;
        @(negedge clk);
        chk("R4 idle after engine", mem_cs_n, 1'b1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            report();
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) tbmem[i] = 16'h0000;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 strobes in reset", {mem_cs_n, mem_oe_n, mem_we_n}, 3'b111);
        chk("R1 flags in reset", {host_ready, eng_ack, host_rd_drive, host_wr_accept,
                                  ext_addr_oe, host_range_err}, 6'b0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 strobes after reset", {mem_cs_n, mem_oe_n, mem_we_n}, 3'b111);

        // Isolated mode: write then read back
        host_op(16'h0012, 16'h0012, 1'b1, 16'hA5A5);
        host_op(16'h0012, 16'h0012, 1'b0, 16'hA5A5);

        // R2: latch holds address captured while ale was high
        @(negedge clk); host_addr_in = 16'h0034; host_ale = 1'b1;
        @(negedge clk); host_ale = 1'b0;
        host_op(16'h1F77, 16'h0034, 1'b1, 16'h5A5A);
        host_op(16'h0BCD, 16'h0034, 1'b0, 16'h5A5A);
        host_ale = 1'b1;

        // R6: engine cycle in isolated mode, high address bits folded away
        eng_op(16'h4040, 1'b1, 16'h1234);
        host_op(16'h0040, 16'h0040, 1'b0, 16'h1234);

        // R3: simultaneous requests, engine first
        @(negedge clk);
        eng_addr = 16'h0041; eng_we = 1'b1; eng_wdata = 16'h7777; eng_req = 1'b1;
        host_addr_in = 16'h0041; host_we = 1'b0; host_req = 1'b1;
        exp_q.push_back(16'h7777);
        @(negedge clk);
        chk("R3 engine wins data", mem_wdata, 16'h7777);
        chk("R3 host buffer off", host_rd_drive, 1'b0);
        @(negedge clk);
        chk("R3 engine ack first", eng_ack, 1'b1);
        chk("R3 host waits", host_ready, 1'b0);
        eng_req = 1'b0;
        @(negedge clk);
        chk("R3 idle gap", mem_cs_n, 1'b1);
        @(negedge clk);
        chk("R3 host cycle select", mem_cs_n, 1'b0);
        chk("R3 host addr", mem_addr, 16'h0041);
        @(negedge clk);
        chk("R3 host served", host_ready, 1'b1);
        host_req = 1'b0;
        @(negedge clk);

        // R8: out-of-window host address in isolated mode
        @(negedge clk); host_addr_in = 16'h2000; host_we = 1'b1; host_req = 1'b1;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R8 range flag", host_range_err, 1'b1);
            chk("R8 no cycle", mem_cs_n, 1'b1);
            chk("R8 no ready", host_ready, 1'b0);
        end
        host_req = 1'b0;
        @(negedge clk);
        chk("R8 flag clears", host_range_err, 1'b0);

        // R7: pass-through mode, full addresses, external RAM (R9 select off)
        mode_xparent = 1'b1;
        host_op(16'h8055, 16'h8055, 1'b1, 16'h0F0F);
        eng_op(16'h9077, 1'b1, 16'hBEEF);
        host_op(16'hC077, 16'hC077, 1'b0, 16'hBEEF);
        host_op(16'h8055, 16'h8055, 1'b0, 16'h0F0F);
        @(negedge clk);
        host_addr_in = 16'hF000; host_req = 1'b1; host_we = 1'b0;
        exp_q.push_back(16'h0000);
        #1 chk("R8 no flag in pass-through", host_range_err, 1'b0);
        @(negedge clk); @(negedge clk);
        host_req = 1'b0;
        @(negedge clk); @(negedge clk);

        chk("R5 all reads seen", 16'(exp_q.size()), 16'd0);
        done = 1'b1;
        report();
    end
endmodule